// File: doc/BRIEF.md
# Speculative-Forward SECDED Read Path

This block sits between a 128-bit data array and whatever consumes its reads. Each read beat carries 128 data bits and 16 stored check bits. The block forwards the raw data to the requester in the same cycle it arrives, so the common error-free case pays no latency. In parallel, it checks every beat with two independent single-error-correct, double-error-detect codes, one for each 64-bit half. Each beat appears again on a checked output exactly two cycles after it arrived.

When the checker finds an error, the speculative beats the requester saw in the two-cycle exposure window are no longer trustworthy. The block raises a correctable or an uncorrectable flag and issues a cancel naming the offending beat by its tag. In the next cycle it issues a second cancel for the beat that followed. The requester drops the cancelled beats and takes their checked copies instead. A correctable beat is repaired in-line. An uncorrectable beat produces no checked copy.

For test, the block can be armed with a 16-bit mask. The mask is XORed into the check bits of the next valid beat, which injects single or double errors without touching the array.

Top module: `sfr_read_path`

## Requirements
- R1: `fwd_valid`, `fwd_tag` and `fwd_data` equal `rd_valid`, `rd_tag` and `rd_word[127:0]` in the same cycle, with no register in between.
- R2: A beat accepted with `rd_valid` in cycle t appears on `cor_valid`/`cor_tag`/`cor_data` in cycle t+2. A beat without errors keeps its data unchanged. Cycles without an accepted beat two cycles earlier show `cor_valid`, `cancel_valid`, `err_ce` and `err_ue` low.
- R3: The encoding for half h (h=0,1) is as follows.
  - The data of the half is `rd_word[64h+63:64h]` and its check byte is `rd_word[128+8h+7:128+8h]`.
  - Data bit j takes the j-th position, counting upward from 3, that is not a power of two.
  - Check bit i (i<7) is the XOR of the data bits whose position has bit i set.
  - Check bit 7 is the XOR of all 64 data bits and check bits 0..6.
- R4: One flipped bit anywhere among the 72 bits of a half gives a correct `cor_data` with `cor_valid` high and `err_ce` high in cycle t+2.
- R5: A single flipped bit in each half of the same beat is still corrected. The beat raises `err_ce`, not `err_ue`.
- R6: Two flipped bits in one half raise `err_ue` in cycle t+2 and hold `cor_valid` low for that beat. `err_ue` and `err_ce` are never high together.
- R7: In the cycle that `err_ce` or `err_ue` is high, `cancel_valid` is high and `cancel_tag` names the tag of the erroneous beat.
- R8: In the cycle after an error indication, `cancel_valid` is high with the tag of the beat accepted one cycle after the erroneous one, if such a beat was accepted. Otherwise no cancel is issued in that cycle.
- R9: A pulse on `inj_arm` latches `inj_mask`. The mask is XORed into `rd_word[143:128]` of the next valid beat accepted after the arming cycle, and into no later beat.
- R10: While `rst_n` is low, and in the first cycle after release, `cor_valid`, `cancel_valid`, `err_ce` and `err_ue` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rd_valid | input | 1 | Read beat present |
| rd_word | input | 144 | Data in [127:0], check bits in [143:128] |
| rd_tag | input | 4 | Requester tag of the beat |
| inj_arm | input | 1 | Arm one-shot check-bit inversion |
| inj_mask | input | 16 | Check bits to invert on the armed beat |
| fwd_valid | output | 1 | Speculative beat valid |
| fwd_data | output | 128 | Speculative, unchecked data |
| fwd_tag | output | 4 | Tag of the speculative beat |
| cancel_valid | output | 1 | Discard the named speculative beat |
| cancel_tag | output | 4 | Tag of the beat to discard |
| cor_valid | output | 1 | Checked beat valid |
| cor_data | output | 128 | Checked, corrected data |
| cor_tag | output | 4 | Tag of the checked beat |
| err_ce | output | 1 | Correctable error on the checked beat |
| err_ue | output | 1 | Uncorrectable error on the checked beat |

## Verification
The bench drives bursts of back-to-back beats with flips in data bits, Hamming check bits and the overall parity bit, in one half or in both halves. A design that miscounted the pipeline would present corrected data or cancels one cycle early or late. A design that decoded a flipped check bit as a data position would corrupt clean data.

Tail cancels are checked both after an error in the middle of a burst and after an error on the last beat of a burst. A design that cancelled unconditionally would then name a beat that never existed. Consecutive errors show whether the tail and a fresh error merge correctly.

Injection is checked for its one-shot nature and for the arming-cycle boundary. A design that applied the mask to the beat arriving with the arm pulse, or kept it for later beats, would raise extra flags.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    typedef enum logic {
        TRK_CLEAN,
        TRK_TAIL
    } trk_state_t;

    typedef enum logic {
        INJ_IDLE,
        INJ_ARMED
    } inj_state_t;

    // Position (1-based Hamming index) of data bit idx: the idx-th
    // non-power-of-two number counting up from 3.
    function automatic int ham_pos(input int idx);
        int cnt;
        int pos;
        cnt = 0;
        pos = 0;
        for (int p = 3; p < 4096; p++) begin
            if (((p & (p - 1)) != 0) && (pos == 0)) begin
                if (cnt == idx) pos = p;
                cnt++;
            end
        end
        return pos;
    endfunction

endpackage

// File: rtl/sfr_syndrome.sv
module sfr_syndrome #(
    parameter int HALF_W = 64,
    parameter int HAM_W  = 7
) (
    input  logic [HALF_W-1:0] data,
    input  logic [HAM_W:0]    chk,
    output logic [HAM_W-1:0]  synd,
    output logic              ovr
);
    logic [HAM_W-1:0] contrib [HALF_W];

    for (genvar j = 0; j < HALF_W; j++) begin : g_pos
        localparam int POS = sfr_pkg::ham_pos(j);
        assign contrib[j] = data[j] ? POS[HAM_W-1:0] : '0;
    end

    always_comb begin
        synd = chk[HAM_W-1:0];
        for (int j = 0; j < HALF_W; j++) begin
            synd = synd ^ contrib[j];
        end
        ovr = ^{data, chk};
    end
endmodule

// File: rtl/sfr_fixup.sv
module sfr_fixup #(
    parameter int HALF_W = 64,
    parameter int HAM_W  = 7
) (
    input  logic [HALF_W-1:0] data,
    input  logic [HAM_W-1:0]  synd,
    input  logic              ovr,
    output logic [HALF_W-1:0] fixed,
    output logic              single,
    output logic              multi
);
    localparam int MAXPOS = HALF_W + HAM_W;

    logic in_range;
    assign in_range = (int'(synd) <= MAXPOS);
    assign single   = ovr && in_range;
    assign multi    = (!ovr && (synd != '0)) || (ovr && !in_range);

    for (genvar j = 0; j < HALF_W; j++) begin : g_fix
        localparam int POS = sfr_pkg::ham_pos(j);
        assign fixed[j] = data[j] ^ (single && (synd == POS[HAM_W-1:0]));
    end
endmodule

// File: rtl/sfr_read_path.sv
module sfr_read_path #(
    parameter  int TAG_W  = 4,
    parameter  int HALF_W = 64,
    parameter  int N_HALF = 2,
    localparam int HAM_W  = $clog2(HALF_W + $clog2(HALF_W) + 1),
    localparam int CHK_W  = HAM_W + 1,
    localparam int DATA_W = N_HALF * HALF_W,
    localparam int ECC_W  = N_HALF * CHK_W,
    localparam int WORD_W = DATA_W + ECC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_word,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              inj_arm,
    input  logic [ECC_W-1:0]  inj_mask,
    output logic              fwd_valid,
    output logic [DATA_W-1:0] fwd_data,
    output logic [TAG_W-1:0]  fwd_tag,
    output logic              cancel_valid,
    output logic [TAG_W-1:0]  cancel_tag,
    output logic              cor_valid,
    output logic [DATA_W-1:0] cor_data,
    output logic [TAG_W-1:0]  cor_tag,
    output logic              err_ce,
    output logic              err_ue
);
    import sfr_pkg::*;

    // Speculative path: no register.
    assign fwd_valid = rd_valid;
    assign fwd_data  = rd_word[DATA_W-1:0];
    assign fwd_tag   = rd_tag;

    // Injection one-shot.
    inj_state_t       inj_state, inj_next;
    logic [ECC_W-1:0] inj_mask_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inj_state  <= INJ_IDLE;
            inj_mask_q <= '0;
        end else begin
            inj_state <= inj_next;
            if (inj_state == INJ_IDLE && inj_arm) inj_mask_q <= inj_mask;
        end
    end

    always_comb begin
        inj_next = inj_state;
        unique case (inj_state)
            INJ_IDLE:  if (inj_arm)  inj_next = INJ_ARMED;
            INJ_ARMED: if (rd_valid) inj_next = INJ_IDLE;
            default:   inj_next = INJ_IDLE;
        endcase
    end

    // Stage 1: captured beat.
    logic              s1_valid;
    logic [TAG_W-1:0]  s1_tag;
    logic [DATA_W-1:0] s1_data;
    logic [ECC_W-1:0]  s1_chk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_tag   <= '0;
            s1_data  <= '0;
            s1_chk   <= '0;
        end else begin
            s1_valid <= rd_valid;
            if (rd_valid) begin
                s1_tag  <= rd_tag;
                s1_data <= rd_word[DATA_W-1:0];
                s1_chk  <= rd_word[WORD_W-1:DATA_W]
                         ^ ((inj_state == INJ_ARMED) ? inj_mask_q : '0);
            end
        end
    end

    // Syndrome per half, then stage 2.
    logic [HAM_W-1:0]  s1_synd [N_HALF];
    logic [N_HALF-1:0] s1_ovr;
    logic              s2_valid;
    logic [TAG_W-1:0]  s2_tag;
    logic [DATA_W-1:0] s2_data;
    logic [HAM_W-1:0]  s2_synd [N_HALF];
    logic [N_HALF-1:0] s2_ovr;
    logic [N_HALF-1:0] h_single, h_multi;

    for (genvar h = 0; h < N_HALF; h++) begin : g_half
        sfr_syndrome #(.HALF_W(HALF_W), .HAM_W(HAM_W)) u_synd (
            .data (s1_data[h*HALF_W +: HALF_W]),
            .chk  (s1_chk[h*CHK_W +: CHK_W]),
            .synd (s1_synd[h]),
            .ovr  (s1_ovr[h])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s2_synd[h] <= '0;
            else if (s1_valid) s2_synd[h] <= s1_synd[h];
        end

        sfr_fixup #(.HALF_W(HALF_W), .HAM_W(HAM_W)) u_fix (
            .data   (s2_data[h*HALF_W +: HALF_W]),
            .synd   (s2_synd[h]),
            .ovr    (s2_ovr[h]),
            .fixed  (cor_data[h*HALF_W +: HALF_W]),
            .single (h_single[h]),
            .multi  (h_multi[h])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s2_valid <= 1'b0;
            s2_tag   <= '0;
            s2_data  <= '0;
            s2_ovr   <= '0;
        end else begin
            s2_valid <= s1_valid;
            if (s1_valid) begin
                s2_tag  <= s1_tag;
                s2_data <= s1_data;
                s2_ovr  <= s1_ovr;
            end
        end
    end

    // Exposure-window tracker.
    trk_state_t trk_state, trk_next;
    logic       hit_ue, hit_ce;

    assign hit_ue = s2_valid && (|h_multi);
    assign hit_ce = s2_valid && (|h_single) && !(|h_multi);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_state <= TRK_CLEAN;
        else        trk_state <= trk_next;
    end

    always_comb begin
        trk_next     = (hit_ce || hit_ue) ? TRK_TAIL : TRK_CLEAN;
        err_ce       = hit_ce;
        err_ue       = hit_ue;
        cor_valid    = s2_valid && !hit_ue;
        cor_tag      = s2_tag;
        cancel_tag   = s2_tag;
        cancel_valid = 1'b0;
        unique case (trk_state)
            TRK_CLEAN: cancel_valid = hit_ce || hit_ue;
            TRK_TAIL:  cancel_valid = s2_valid;
            default:   cancel_valid = 1'b0;
        endcase
    end
endmodule

// File: rtl/sfr_read_path_chk.sv
module sfr_read_path_chk #(
    parameter int TAG_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic [TAG_W-1:0] rd_tag,
    input logic             cancel_valid,
    input logic [TAG_W-1:0] cancel_tag,
    input logic             cor_valid,
    input logic [TAG_W-1:0] cor_tag,
    input logic             err_ce,
    input logic             err_ue
);
    p_cor_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cor_valid |-> ($past(rd_valid, 2) && cor_tag == $past(rd_tag, 2)));

    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_ce && err_ue));

    p_ue_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
        err_ue |-> !cor_valid);

    p_cancel_on_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ce || err_ue) |-> cancel_valid);

    p_cancel_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_valid |-> ($past(rd_valid, 2) && cancel_tag == $past(rd_tag, 2)));

    p_tail_cancel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_ce || err_ue) |=> (cancel_valid == $past(rd_valid, 2)));
endmodule

bind sfr_read_path sfr_read_path_chk #(.TAG_W(TAG_W)) u_sfr_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_valid     (rd_valid),
    .rd_tag       (rd_tag),
    .cancel_valid (cancel_valid),
    .cancel_tag   (cancel_tag),
    .cor_valid    (cor_valid),
    .cor_tag      (cor_tag),
    .err_ce       (err_ce),
    .err_ue       (err_ue)
);

// File: tb/sfr_read_path_bench.sv
module sfr_read_path_bench;
    localparam int NB = 8;
    localparam int NI = NB + 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         rd_valid = 1'b0;
    logic [143:0] rd_word = '0;
    logic [3:0]   rd_tag = '0;
    logic         inj_arm = 1'b0;
    logic [15:0]  inj_mask = '0;
    logic         fwd_valid, cancel_valid, cor_valid, err_ce, err_ue;
    logic [127:0] fwd_data, cor_data;
    logic [3:0]   fwd_tag, cancel_tag, cor_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sfr_read_path u_sfr_read_path (
        .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_word(rd_word),
        .rd_tag(rd_tag), .inj_arm(inj_arm), .inj_mask(inj_mask),
        .fwd_valid(fwd_valid), .fwd_data(fwd_data), .fwd_tag(fwd_tag),
        .cancel_valid(cancel_valid), .cancel_tag(cancel_tag),
        .cor_valid(cor_valid), .cor_data(cor_data), .cor_tag(cor_tag),
        .err_ce(err_ce), .err_ue(err_ue)
    );

    // Scenario description
    logic [127:0] b_data  [NB];
    logic [143:0] b_flip  [NB];
    logic         b_valid [NB];
    logic         b_arm   [NB];
    logic [15:0]  b_mask;
    int           inj_beat;
    int           st      [NB];

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Spec encoding (R3), built from bit positions.
    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [6:0] h = '0;
        int pos = 3;
        for (int j = 0; j < 64; j++) begin
            while ((pos & (pos - 1)) == 0) pos++;
            if (d[j]) h = h ^ pos[6:0];
            pos++;
        end
        return {(^d) ^ (^h), h};
    endfunction

    task automatic clear_beats();
        for (int k = 0; k < NB; k++) begin
            b_data[k]  = '0;
            b_flip[k]  = '0;
            b_valid[k] = 1'b0;
            b_arm[k]   = 1'b0;
        end
        b_mask   = '0;
        inj_beat = -1;
    endtask

    task automatic run(input string name);
        logic [143:0] eff;
        int worst;
        for (int k = 0; k < NB; k++) begin
            eff = b_flip[k];
            if (k == inj_beat) eff = eff ^ {b_mask, 128'b0};
            worst = 0;
            for (int h = 0; h < 2; h++) begin
                int n;
                n = $countones(eff[64*h +: 64]) + $countones(eff[128 + 8*h +: 8]);
                if (n > worst) worst = n;
            end
            st[k] = b_valid[k] ? ((worst >= 2) ? 2 : worst) : 0;
        end
        for (int k = 0; k < NI; k++) begin
            int i;
            bit ev, pe, ex_cancel;
            @(negedge clk);
            i = k - 2;
            ev = (i >= 0 && i < NB) ? b_valid[i] : 1'b0;
            pe = (i >= 1 && i <= NB) ? (st[i-1] != 0) : 1'b0;
            if (ev) begin
                check(err_ce == (st[i] == 1), {name, " R4 err_ce"}, 128'(err_ce), 128'(st[i] == 1));
                check(err_ue == (st[i] == 2), {name, " R6 err_ue"}, 128'(err_ue), 128'(st[i] == 2));
                check(cor_valid == (st[i] != 2), {name, " R2 cor_valid"}, 128'(cor_valid), 128'(st[i] != 2));
                if (st[i] != 2) begin
                    check(cor_data == b_data[i], {name, " R2 cor_data"}, cor_data, b_data[i]);
                    check(cor_tag == 4'(i + 3), {name, " R2 cor_tag"}, 128'(cor_tag), 128'(i + 3));
                end
                ex_cancel = (st[i] != 0) || pe;
            end else begin
                check(!cor_valid && !err_ce && !err_ue, {name, " R2 idle outputs"},
                      128'({cor_valid, err_ce, err_ue}), 128'(0));
                ex_cancel = 1'b0;
            end
            check(cancel_valid == ex_cancel, {name, " R7 R8 cancel_valid"},
                  128'(cancel_valid), 128'(ex_cancel));
            if (ex_cancel)
                check(cancel_tag == 4'(i + 3), {name, " R7 cancel_tag"},
                      128'(cancel_tag), 128'(i + 3));
            // drive this iteration's beat
            if (k < NB) begin
                logic [63:0] d0, d1;
                d0 = b_data[k][63:0];
                d1 = b_data[k][127:64];
                rd_valid = b_valid[k];
                rd_tag   = 4'(k + 3);
                rd_word  = {ref_chk(d1), ref_chk(d0), b_data[k]} ^ b_flip[k];
                inj_arm  = b_arm[k];
                inj_mask = b_mask;
            end else begin
                rd_valid = 1'b0;
                inj_arm  = 1'b0;
            end
            #1;
            check(fwd_valid == rd_valid && fwd_tag == rd_tag && fwd_data == rd_word[127:0],
                  {name, " R1 forward"}, fwd_data, rd_word[127:0]);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(!cor_valid && !cancel_valid && !err_ce && !err_ue, "reset R10 outputs low",
              128'({cor_valid, cancel_valid, err_ce, err_ue}), 128'(0));
        rst_n = 1'b1;
        @(negedge clk);
        check(!cor_valid && !cancel_valid && !err_ce && !err_ue, "after reset R10",
              128'({cor_valid, cancel_valid, err_ce, err_ue}), 128'(0));
    endtask

    task automatic t_clean();
        clear_beats();
        for (int k = 0; k < 4; k++) begin
            b_valid[k] = 1'b1;
            b_data[k]  = {4{32'hA5C3_0000 + 32'(k * 97)}} ^ {k[3:0], 124'h0};
        end
        b_data[3] = '1;
        run("clean R2 R3");
    endtask

    task automatic t_single_data();
        clear_beats();
        for (int k = 0; k < 4; k++) begin
            b_valid[k] = 1'b1;
            b_data[k]  = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210} + 128'(k);
        end
        b_flip[1][37]  = 1'b1;
        b_flip[3][127] = 1'b1;
        run("single data R4 R8");
    endtask

    task automatic t_single_check();
        clear_beats();
        for (int k = 0; k < 3; k++) begin
            b_valid[k] = 1'b1;
            b_data[k]  = {2{64'hDEAD_BEEF_0BAD_F00D}} >> k;
        end
        b_flip[0][138] = 1'b1;
        b_flip[2][143] = 1'b1;
        run("check-bit flip R4");
    endtask

    task automatic t_both_halves();
        clear_beats();
        b_valid[0] = 1'b1;
        b_data[0]  = {64'h1111_2222_3333_4444, 64'h5555_6666_7777_8888};
        b_flip[0][0]   = 1'b1;
        b_flip[0][100] = 1'b1;
        b_valid[2] = 1'b1;
        b_data[2]  = 128'h42;
        run("both halves R5 R8");
    endtask

    task automatic t_double();
        clear_beats();
        for (int k = 0; k < 3; k++) begin
            b_valid[k] = 1'b1;
            b_data[k]  = 128'hCAFE << (8 * k);
        end
        b_flip[1][70] = 1'b1;
        b_flip[1][90] = 1'b1;
        b_flip[2][5]  = 1'b1;
        run("double R6 R7 R8");
    endtask

    task automatic t_inject();
        clear_beats();
        for (int k = 0; k < 5; k++) b_data[k] = 128'h77 + 128'(k);
        b_arm[0]   = 1'b1;
        b_valid[0] = 1'b1;
        b_mask     = 16'h0200;
        b_valid[2] = 1'b1;
        b_valid[3] = 1'b1;
        inj_beat   = 2;
        run("inject single R9");
        clear_beats();
        for (int k = 0; k < 3; k++) b_data[k] = 128'h9 << k;
        b_arm[0]   = 1'b1;
        b_mask     = 16'h0005;
        b_valid[1] = 1'b1;
        b_valid[2] = 1'b1;
        inj_beat   = 1;
        run("inject double R9");
    endtask

    initial begin
        t_reset();
        t_clean();
        t_single_data();
        t_single_check();
        t_both_halves();
        t_double();
        t_inject();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule